// File: doc/BRIEF.md
# Rate-Sensor Power-On Self-Test Sequencer

This controller runs a power-on self-test of an angular rate sensor. The sensor has two test pins. Raising the first pulls the rate reading down, and raising the second pushes it up. The controller idles until it receives a start pulse. It then waits a fixed number of clock cycles for the sensor output to settle. Next it averages a baseline from the rate samples that a polling host hands it. The samples are signed 12-bit values, zero at rest, with a valid strobe.

After the baseline, the controller raises the negative-going pin on its own. It discards a set number of samples while the sensor moves, averages the shifted output, and releases the pin. It discards samples again while the output recovers. It then runs the same steps with the positive-going pin. The two pins are never high together, because doing so can bias the null.

Each delta is the average taken with the pin high minus the baseline. Each delta is judged against its own window: the negative pin must give −376 to −121 LSB and the positive pin must give +121 to +376 LSB. The deltas and the two verdicts stay on the outputs until the next start.

The states and transitions are:

| From | To | Condition |
|---|---|---|
| IDLE | WARM | start |
| WARM | BASE | WARMUP_CYC cycles counted |
| BASE | NDROP | 2^AVG_LOG2 samples accumulated |
| NDROP | NAVG | DISCARD samples dropped |
| NAVG | NREL | 2^AVG_LOG2 samples accumulated |
| NREL | PDROP | DISCARD samples dropped |
| PDROP | PAVG | DISCARD samples dropped |
| PAVG | PREL | 2^AVG_LOG2 samples accumulated |
| PREL | JUDGE | DISCARD samples dropped |
| JUDGE | IDLE | unconditional |

The negative-going pin is high in NDROP and NAVG. The positive-going pin is high in PDROP and PAVG. Busy is high in every state except IDLE.

Top module: `gyro_selftest_seq`

## Requirements
- R1: After reset, busy, both test pins, both pass flags and both deltas are 0.
- R2: In IDLE, a start pulse raises busy on the next cycle and clears both deltas and both pass flags. A start while busy is ignored: the run in progress continues unchanged.
- R3: For the WARMUP_CYC clock cycles after the run begins, both pins stay low and every sample is ignored, even when it is marked valid.
- R4: The baseline is the sum of 2^AVG_LOG2 valid samples shifted right arithmetically by AVG_LOG2, which gives the floor of the mean.
- R5: The negative-going pin is raised alone. The first DISCARD valid samples are then dropped, and the next 2^AVG_LOG2 are averaged. delta_neg equals that average minus the baseline.
- R6: The negative-going pin is released, and DISCARD samples are dropped. Only then is the positive-going pin raised alone, with the same drop and average steps. delta_pos equals that average minus the baseline. A final DISCARD samples are dropped after the positive-going pin is released.
- R7: The two test pins are never high in the same cycle.
- R8: At the end of the run, pass_neg is 1 exactly when −376 ≤ delta_neg ≤ −121. pass_pos is 1 exactly when +121 ≤ delta_pos ≤ +376. The verdicts appear on the same edge on which busy falls.
- R9: While idle and without a start, the deltas and pass flags hold their values, whatever samples arrive.
- R10: A sample with smp_valid low is neither counted nor accumulated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins a run when idle |
| smp_valid | input | 1 | Marks smp_data as a new sample |
| smp_data | input | 12 | Signed rate sample, 0 at rest |
| st_neg | output | 1 | Negative-going test pin level |
| st_pos | output | 1 | Positive-going test pin level |
| busy | output | 1 | High while a run is in progress |
| pass_neg | output | 1 | Negative pin response in window |
| pass_pos | output | 1 | Positive pin response in window |
| delta_neg | output | 13 | Signed shift from negative pin |
| delta_pos | output | 13 | Signed shift from positive pin |

## Verification
A state that advances on the wrong count shows up directly on the pin outputs. A pin rises a few samples early or late, and the deltas then pick up settling samples or baseline samples with the wrong offset. A wrong accumulator or baseline register shows up in the deltas, at the end of the averaging phase that uses it. The noise pattern on the samples makes a single-sample capture differ from a true four-sample mean. A wrong window comparison shows up only at the JUDGE edge. It is caught by sweeping each delta across the limits and one LSB beyond them.

// File: rtl/gst_pkg.sv
package gst_pkg;
    typedef enum logic [3:0] {
        S_IDLE,
        S_WARM,
        S_BASE,
        S_NDROP,
        S_NAVG,
        S_NREL,
        S_PDROP,
        S_PAVG,
        S_PREL,
        S_JUDGE
    } seq_state_t;
endpackage

// File: rtl/gst_accum.sv
module gst_accum #(
    parameter int SMP_W    = 12,
    parameter int AVG_LOG2 = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clr,
    input  logic                    add,
    input  logic signed [SMP_W-1:0] din,
    output logic signed [SMP_W-1:0] avg_nx
);
    localparam int SUM_W = SMP_W + AVG_LOG2;

    logic signed [SUM_W-1:0] sum_q;
    logic signed [SUM_W-1:0] sum_nx;

    // Running sum including the sample presented this cycle.
    assign sum_nx = sum_q + SUM_W'(din);
    assign avg_nx = SMP_W'(sum_nx >>> AVG_LOG2);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            sum_q <= '0;
        else if (clr)
            sum_q <= '0;
        else if (add)
            sum_q <= sum_nx;
    end
endmodule

// File: rtl/gst_window.sv
module gst_window #(
    parameter int DW = 13,
    parameter int LO = 121,
    parameter int HI = 376
) (
    input  logic signed [DW-1:0] d,
    output logic                 ok
);
    localparam logic signed [DW-1:0] LO_V = DW'(LO);
    localparam logic signed [DW-1:0] HI_V = DW'(HI);

    assign ok = (d >= LO_V) && (d <= HI_V);
endmodule

// File: rtl/gyro_selftest_seq.sv
module gyro_selftest_seq
    import gst_pkg::*;
#(
    parameter int SMP_W      = 12,
    parameter int AVG_LOG2   = 2,
    parameter int DISCARD    = 4,
    parameter int WARMUP_CYC = 1000,
    parameter int ST_MIN     = 121,
    parameter int ST_MAX     = 376
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic                    smp_valid,
    input  logic signed [SMP_W-1:0] smp_data,
    output logic                    st_neg,
    output logic                    st_pos,
    output logic                    busy,
    output logic                    pass_neg,
    output logic                    pass_pos,
    output logic signed [SMP_W:0]   delta_neg,
    output logic signed [SMP_W:0]   delta_pos
);
    localparam int DW     = SMP_W + 1;
    localparam int N_AVG  = 1 << AVG_LOG2;
    localparam int MAX_A  = (WARMUP_CYC > N_AVG) ? WARMUP_CYC : N_AVG;
    localparam int MAX_C  = (MAX_A > DISCARD) ? MAX_A : DISCARD;
    localparam int CNT_W  = $clog2(MAX_C + 1);
    localparam logic [CNT_W-1:0] LAST_WARM = CNT_W'(WARMUP_CYC - 1);
    localparam logic [CNT_W-1:0] LAST_AVG  = CNT_W'(N_AVG - 1);
    localparam logic [CNT_W-1:0] LAST_DROP = CNT_W'(DISCARD - 1);

    seq_state_t state_q, state_nx;
    logic [CNT_W-1:0] cnt_q;
    logic signed [SMP_W-1:0] base_q;
    logic signed [SMP_W-1:0] avg_nx;
    logic avg_phase, drop_phase;
    logic warm_done, avg_done, drop_done;
    logic ok_neg, ok_pos;

    assign warm_done = (cnt_q == LAST_WARM);
    assign avg_done  = smp_valid && (cnt_q == LAST_AVG);
    assign drop_done = smp_valid && (cnt_q == LAST_DROP);

    // Next-state logic
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            S_IDLE:  if (start)     state_nx = S_WARM;
            S_WARM:  if (warm_done) state_nx = S_BASE;
            S_BASE:  if (avg_done)  state_nx = S_NDROP;
            S_NDROP: if (drop_done) state_nx = S_NAVG;
            S_NAVG:  if (avg_done)  state_nx = S_NREL;
            S_NREL:  if (drop_done) state_nx = S_PDROP;
            S_PDROP: if (drop_done) state_nx = S_PAVG;
            S_PAVG:  if (avg_done)  state_nx = S_PREL;
            S_PREL:  if (drop_done) state_nx = S_JUDGE;
            S_JUDGE:                state_nx = S_IDLE;
            default:                state_nx = S_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_nx;
    end

    // Outputs decoded from the state
    always_comb begin
        st_neg     = 1'b0;
        st_pos     = 1'b0;
        avg_phase  = 1'b0;
        drop_phase = 1'b0;
        unique case (state_q)
            S_NDROP: begin st_neg = 1'b1; drop_phase = 1'b1; end
            S_NAVG:  begin st_neg = 1'b1; avg_phase  = 1'b1; end
            S_PDROP: begin st_pos = 1'b1; drop_phase = 1'b1; end
            S_PAVG:  begin st_pos = 1'b1; avg_phase  = 1'b1; end
            S_BASE:  avg_phase  = 1'b1;
            S_NREL,
            S_PREL:  drop_phase = 1'b1;
            default: ;
        endcase
        busy = (state_q != S_IDLE);
    end

    gst_accum #(
        .SMP_W   (SMP_W),
        .AVG_LOG2(AVG_LOG2)
    ) u_accum (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (!avg_phase),
        .add   (avg_phase && smp_valid),
        .din   (smp_data),
        .avg_nx(avg_nx)
    );

    gst_window #(.DW(DW), .LO(-ST_MAX), .HI(-ST_MIN)) u_win_neg (
        .d (delta_neg),
        .ok(ok_neg)
    );

    gst_window #(.DW(DW), .LO(ST_MIN), .HI(ST_MAX)) u_win_pos (
        .d (delta_pos),
        .ok(ok_pos)
    );

    // Phase counter, baseline and result registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q     <= '0;
            base_q    <= '0;
            delta_neg <= '0;
            delta_pos <= '0;
            pass_neg  <= 1'b0;
            pass_pos  <= 1'b0;
        end else begin
            if (state_nx != state_q)
                cnt_q <= '0;
            else if (state_q == S_WARM || ((avg_phase || drop_phase) && smp_valid))
                cnt_q <= cnt_q + 1'b1;

            if (state_q == S_IDLE && start) begin
                delta_neg <= '0;
                delta_pos <= '0;
                pass_neg  <= 1'b0;
                pass_pos  <= 1'b0;
            end
            if (state_q == S_BASE && avg_done)
                base_q <= avg_nx;
            if (state_q == S_NAVG && avg_done)
                delta_neg <= {avg_nx[SMP_W-1], avg_nx} - {base_q[SMP_W-1], base_q};
            if (state_q == S_PAVG && avg_done)
                delta_pos <= {avg_nx[SMP_W-1], avg_nx} - {base_q[SMP_W-1], base_q};
            if (state_q == S_JUDGE) begin
                pass_neg <= ok_neg;
                pass_pos <= ok_pos;
            end
        end
    end
endmodule

// File: rtl/gyro_selftest_chk.sv
module gyro_selftest_chk #(
    parameter int DW = 13
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 start,
    input logic                 st_neg,
    input logic                 st_pos,
    input logic                 busy,
    input logic                 pass_neg,
    input logic                 pass_pos,
    input logic signed [DW-1:0] delta_neg,
    input logic signed [DW-1:0] delta_pos
);
    p_one_pin_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(st_neg && st_pos));

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!st_neg && !st_pos));

    p_start_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    p_start_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> (delta_neg == '0 && delta_pos == '0 && !pass_neg && !pass_pos));

    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> ($stable(delta_neg) && $stable(delta_pos)
                               && $stable(pass_neg) && $stable(pass_pos)));

    p_verdict_neg_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pass_neg) |-> $fell(busy));

    p_verdict_pos_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pass_pos) |-> $fell(busy));

    p_order_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_pos) |-> (!st_neg && $past(!st_neg)));
endmodule

bind gyro_selftest_seq gyro_selftest_chk #(.DW(SMP_W + 1)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .st_neg   (st_neg),
    .st_pos   (st_pos),
    .busy     (busy),
    .pass_neg (pass_neg),
    .pass_pos (pass_pos),
    .delta_neg(delta_neg),
    .delta_pos(delta_pos)
);

// File: tb/gyro_selftest_seq_tb.sv
module gyro_selftest_seq_tb;
    localparam int CLK_PERIOD = 10;
    localparam int WARM = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic smp_valid = 1'b0;
    logic signed [11:0] smp_data = '0;
    logic st_neg, st_pos, busy, pass_neg, pass_pos;
    logic signed [12:0] delta_neg, delta_pos;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    bit both_seen = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gyro_selftest_seq #(
        .SMP_W(12), .AVG_LOG2(2), .DISCARD(2), .WARMUP_CYC(WARM),
        .ST_MIN(121), .ST_MAX(376)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .smp_valid(smp_valid), .smp_data(smp_data),
        .st_neg(st_neg), .st_pos(st_pos), .busy(busy),
        .pass_neg(pass_neg), .pass_pos(pass_pos),
        .delta_neg(delta_neg), .delta_pos(delta_pos)
    );

    always @(negedge clk) begin
        cycles++;
        if (st_neg && st_pos) both_seen = 1;
        if (cycles > 150000) begin
            total++; bad++;
            $display("FAIL watchdog: run hung, got cycles=%0d exp below 150000", cycles);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic check(input string req, input int got, input int exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %0d exp %0d", req, got, exp);
        end
    endtask

    // One complete run with baseline b and pin responses dn and dp.
    task automatic run_one(input int b, input int dn, input int dp, input bit poke);
        int noise[4] = '{1, -3, 2, -2};
        int k = 0;
        bit poked = 0;
        bit pos_before_neg = 0;
        bit neg_seen = 0;
        int v;
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check("R2 busy after start", int'(busy), 1);
        check("R2 delta_neg cleared", int'(delta_neg), 0);
        // Warm-up window: valid garbage that must be ignored (R3).
        for (int i = 0; i < WARM; i++) begin
            if (st_neg || st_pos) check("R3 pins low in warm-up", 1, 0);
            smp_valid = 1'b1;
            smp_data = 12'sd2000;
            @(negedge clk);
        end
        while (busy) begin
            if (st_neg) neg_seen = 1;
            if (st_pos && !neg_seen) pos_before_neg = 1;
            if (poke && st_neg && !poked) begin
                poked = 1;
                smp_valid = 1'b0;
                start = 1'b1;
                @(negedge clk);
                start = 1'b0;
                check("R2 start ignored while busy", int'(st_neg), 1);
                continue;
            end
            v = b + (st_neg ? dn : 0) + (st_pos ? dp : 0) + noise[k % 4];
            k++;
            smp_valid = 1'b1;
            smp_data = 12'(v);
            @(negedge clk);
            // Cycle with valid low carrying garbage (R10).
            smp_valid = 1'b0;
            smp_data = -12'sd1900;
            @(negedge clk);
        end
        smp_valid = 1'b0;
        check("R5 delta_neg", int'(delta_neg), dn);
        check("R6 delta_pos", int'(delta_pos), dp);
        check("R8 pass_neg", int'(pass_neg), int'(dn >= -376 && dn <= -121));
        check("R8 pass_pos", int'(pass_pos), int'(dp >= 121 && dp <= 376));
        check("R6 positive pin only after negative", int'(pos_before_neg), 0);
        check("R4 R10 sample count", k, 20);
    endtask

    initial begin
        int dn_l[6] = '{-120, -121, -221, -376, -377, 0};
        int dp_l[6] = '{120, 121, 221, 376, 377, -221};
        int n = 0;
        logic signed [12:0] hold_n, hold_p;
        logic hold_fn, hold_fp;
        repeat (3) @(negedge clk);
        check("R1 busy", int'(busy), 0);
        check("R1 pins", int'(st_neg) + int'(st_pos), 0);
        check("R1 pass", int'(pass_neg) + int'(pass_pos), 0);
        check("R1 deltas", int'(delta_neg) + int'(delta_pos), 0);
        rst_n = 1'b1;
        for (int i = 0; i < 6; i++) begin
            for (int j = 0; j < 6; j++) begin
                run_one((n * 37) % 200 - 100, dn_l[i], dp_l[j], n == 1);
                n++;
            end
        end
        // Hold while idle (R9).
        hold_n = delta_neg; hold_p = delta_pos;
        hold_fn = pass_neg; hold_fp = pass_pos;
        for (int i = 0; i < 20; i++) begin
            smp_valid = 1'b1;
            smp_data = 12'(i * 97);
            @(negedge clk);
        end
        smp_valid = 1'b0;
        check("R9 delta_neg held", int'(delta_neg), int'(hold_n));
        check("R9 delta_pos held", int'(delta_pos), int'(hold_p));
        check("R9 pass held", int'({hold_fn, hold_fp}), int'({pass_neg, pass_pos}));
        check("R7 pins never together", int'(both_seen), 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule